// File: doc/BRIEF.md
# Cache-Line Fetch Group Extractor

This block takes one instruction-cache line that has just come back, together with the fetch address of the thread chosen for this cycle. It cuts a group of fixed four-byte instructions out of that line and presents them in a slot array. Each slot carries the instruction word, its word-aligned address, the address the front end expects to follow it, and a sequence number taken from a counter shared by all groups. A per-word predecode mask marks which words are control instructions and which are quiesce instructions. A per-word predictor view supplies a taken flag and a target address for each word.

A group starts at the word that the fetch address points to. It closes at the first of four events: the last word of the line, the fetch-width limit, a control instruction predicted taken, or a quiesce instruction. The block then updates its thread address pair to the address after the group. It also counts predicted-taken branches and raises a one-cycle quiesce request when a quiesce instruction was emitted. All results are registered and appear in the cycle after the request is sampled. If an interrupt is waiting and the access is not in physical-address mode, the request produces no group.

Top module: `fgx_group_extract`

## Requirements
- R1: After reset, every output is zero: no valid group, count 0, all slot fields 0, thread address pair 0, taken-branch count 0, quiesce request low.
- R2: The line base is the fetch address with its low log2(LINE_BYTES) bits cleared. The first emitted word has index fetch_pc[5:2] (64-byte line). Slot addresses are word aligned, so the two low bits of the fetch address are dropped.
- R3: Extraction never passes the end of the line. A group that starts at word index 14 of a 16-word line holds exactly two instructions.
- R4: A group holds at most FETCH_W instructions (4 by default). Slot s holds the s-th emitted instruction, and slots at or above the count read as zero with their valid bit low.
- R5: For a word whose control bit is 0, the recorded target is its own address plus 4, and the next slot continues at that address.
- R6: For a word whose control bit is 1, the recorded target and the next address both come from that word's predictor target, whether it is predicted taken or not. If its taken bit is 1, the group ends after it and the taken-branch counter rises by one.
- R7: A word whose quiesce bit is 1 is emitted and counted, ends the group, and raises quiesce_req for exactly the cycle in which that group is presented.
- R8: The slots of a group carry consecutive sequence numbers. The first number of each group follows directly on the last number of the previous group.
- R9: When fetch_go is high, intr_pending is high and phys_mode is low, no group is produced. The sequence counter, the taken-branch counter and the thread address pair stay unchanged. With phys_mode high, the request proceeds normally.
- R10: After a group, pc_q equals the address after the group's last instruction and pc_next_q equals pc_q + 4. grp_valid is high exactly when the count is non-zero. A cycle without a request shows an empty group and keeps the address pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_go | input | 1 | A line and fetch address are presented this cycle |
| fetch_pc | input | ADDR_W | Fetch address of the selected thread |
| line_data | input | LINE_BYTES*8 | Cache line, word w at bits [32w+31:32w] |
| ctrl_mask | input | LINE_BYTES/4 | Bit w: word w is a control instruction |
| quiesce_mask | input | LINE_BYTES/4 | Bit w: word w is a quiesce instruction |
| pred_taken | input | LINE_BYTES/4 | Bit w: predicted direction for word w (1 = taken) |
| pred_target | input | (LINE_BYTES/4)*ADDR_W | Predicted next address for word w at [ADDR_W*w +: ADDR_W] |
| intr_pending | input | 1 | An interrupt is waiting |
| phys_mode | input | 1 | The access uses physical addressing |
| grp_valid | output | 1 | At least one instruction was emitted |
| grp_count | output | $clog2(FETCH_W+1) | Number of instructions in the group |
| slot_valid | output | FETCH_W | Per-slot valid |
| slot_inst | output | FETCH_W*32 | Per-slot instruction word |
| slot_pc | output | FETCH_W*ADDR_W | Per-slot word-aligned address |
| slot_tgt | output | FETCH_W*ADDR_W | Per-slot expected following address |
| slot_seq | output | FETCH_W*SEQ_W | Per-slot sequence number |
| pc_q | output | ADDR_W | Thread address after the last group |
| pc_next_q | output | ADDR_W | pc_q plus 4 |
| quiesce_req | output | 1 | Group ended on a quiesce instruction |
| taken_cnt | output | SEQ_W | Count of predicted-taken branches emitted |

## Verification
The bench starts a group two words before the end of the line, from an address with its low bits set. A design that wrapped the offset would emit words from the start of the line, and one that kept the low bits would report unaligned slot addresses. It places a control word predicted not taken whose target lies outside the line. A design that added 4 instead of using the predictor target would give the next slot the wrong address. It also places a taken branch and a quiesce word in mid-group. A design that failed to stop there would emit extra slots, skip the counter update or drop the quiesce pulse. The interrupt-blocked request is followed by a physical-mode request, which catches a design that blocks both or advances the sequence counter on a suppressed cycle.

// File: rtl/fgx_pkg.sv
package fgx_pkg;
  localparam int INST_BYTES = 4;
  localparam int INST_W     = 32;
  typedef logic [INST_W-1:0] fgx_word_t;
endpackage

// File: rtl/fgx_accum.sv
module fgx_accum #(
  parameter int W      = 16,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [STEP_W-1:0] step,
  output logic [W-1:0]      q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= q + W'(step);
  end
endmodule

// File: rtl/fgx_walker.sv
module fgx_walker #(
  parameter int FETCH_W    = 4,
  parameter int LINE_BYTES = 64,
  parameter int ADDR_W     = 32,
  localparam int WORDS = LINE_BYTES / fgx_pkg::INST_BYTES,
  localparam int WIDX  = $clog2(WORDS),
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int CW    = $clog2(FETCH_W + 1)
) (
  input  logic [ADDR_W-1:0]         fetch_pc,
  input  logic [WORDS-1:0]          ctrl_mask,
  input  logic [WORDS-1:0]          quiesce_mask,
  input  logic [WORDS-1:0]          pred_taken,
  input  logic [WORDS*ADDR_W-1:0]   pred_target,
  output logic [FETCH_W-1:0]        w_valid,
  output logic [FETCH_W*WIDX-1:0]   w_idx,
  output logic [FETCH_W*ADDR_W-1:0] w_pc,
  output logic [FETCH_W*ADDR_W-1:0] w_tgt,
  output logic [CW-1:0]             w_count,
  output logic [ADDR_W-1:0]         w_next_pc,
  output logic                      w_taken,
  output logic                      w_quiesce
);
  function automatic logic [ADDR_W-1:0] word_pc(input logic [ADDR_W-1:0] a);
    return a & ~ADDR_W'(fgx_pkg::INST_BYTES - 1);
  endfunction

  function automatic logic [OFF_W:0] start_off(input logic [ADDR_W-1:0] a);
    return {1'b0, a[OFF_W-1:2], 2'b00};
  endfunction

  function automatic logic [ADDR_W-1:0] pc_after(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(fgx_pkg::INST_BYTES);
  endfunction

  logic [ADDR_W-1:0] pc_w, nx_w;
  logic [OFF_W:0]    off_w;
  logic [WIDX-1:0]   wi;
  logic              run, is_ctl;

  always_comb begin
    pc_w      = word_pc(fetch_pc);
    off_w     = start_off(fetch_pc);
    run       = 1'b1;
    wi        = '0;
    nx_w      = '0;
    is_ctl    = 1'b0;
    w_valid   = '0;
    w_idx     = '0;
    w_pc      = '0;
    w_tgt     = '0;
    w_count   = '0;
    w_taken   = 1'b0;
    w_quiesce = 1'b0;
    for (int s = 0; s < FETCH_W; s++) begin
      if (run && (off_w < (OFF_W+1)'(LINE_BYTES))) begin
        wi     = off_w[OFF_W-1:2];
        is_ctl = ctrl_mask[wi];
        nx_w   = is_ctl ? pred_target[int'(wi)*ADDR_W +: ADDR_W] : pc_after(pc_w);
        w_valid[s]                  = 1'b1;
        w_idx[s*WIDX +: WIDX]       = wi;
        w_pc[s*ADDR_W +: ADDR_W]    = pc_w;
        w_tgt[s*ADDR_W +: ADDR_W]   = nx_w;
        w_count                     = w_count + CW'(1);
        if (is_ctl && pred_taken[wi]) begin
          w_taken = 1'b1;
          run     = 1'b0;
        end
        if (quiesce_mask[wi]) begin
          w_quiesce = 1'b1;
          run       = 1'b0;
        end
        pc_w  = nx_w;
        off_w = off_w + (OFF_W+1)'(fgx_pkg::INST_BYTES);
      end else begin
        run = 1'b0;
      end
    end
    w_next_pc = pc_w;
  end
endmodule

// File: rtl/fgx_group_extract.sv
module fgx_group_extract #(
  parameter int FETCH_W    = 4,
  parameter int LINE_BYTES = 64,
  parameter int ADDR_W     = 32,
  parameter int SEQ_W      = 16,
  localparam int WORDS = LINE_BYTES / fgx_pkg::INST_BYTES,
  localparam int WIDX  = $clog2(WORDS),
  localparam int CW    = $clog2(FETCH_W + 1),
  localparam int IW    = fgx_pkg::INST_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fetch_go,
  input  logic [ADDR_W-1:0]         fetch_pc,
  input  logic [LINE_BYTES*8-1:0]   line_data,
  input  logic [WORDS-1:0]          ctrl_mask,
  input  logic [WORDS-1:0]          quiesce_mask,
  input  logic [WORDS-1:0]          pred_taken,
  input  logic [WORDS*ADDR_W-1:0]   pred_target,
  input  logic                      intr_pending,
  input  logic                      phys_mode,
  output logic                      grp_valid,
  output logic [CW-1:0]             grp_count,
  output logic [FETCH_W-1:0]        slot_valid,
  output logic [FETCH_W*IW-1:0]     slot_inst,
  output logic [FETCH_W*ADDR_W-1:0] slot_pc,
  output logic [FETCH_W*ADDR_W-1:0] slot_tgt,
  output logic [FETCH_W*SEQ_W-1:0]  slot_seq,
  output logic [ADDR_W-1:0]         pc_q,
  output logic [ADDR_W-1:0]         pc_next_q,
  output logic                      quiesce_req,
  output logic [SEQ_W-1:0]          taken_cnt
);
  logic [FETCH_W-1:0]        w_valid;
  logic [FETCH_W*WIDX-1:0]   w_idx;
  logic [FETCH_W*ADDR_W-1:0] w_pc, w_tgt;
  logic [CW-1:0]             w_count;
  logic [ADDR_W-1:0]         w_next_pc;
  logic                      w_taken, w_quiesce;

  fgx_walker #(.FETCH_W(FETCH_W), .LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W)) walk_i (
    .fetch_pc(fetch_pc), .ctrl_mask(ctrl_mask), .quiesce_mask(quiesce_mask),
    .pred_taken(pred_taken), .pred_target(pred_target),
    .w_valid(w_valid), .w_idx(w_idx), .w_pc(w_pc), .w_tgt(w_tgt),
    .w_count(w_count), .w_next_pc(w_next_pc), .w_taken(w_taken), .w_quiesce(w_quiesce)
  );

  // Request suppressed by a waiting interrupt outside physical mode
  logic blocked, fire;
  assign blocked = fetch_go && intr_pending && !phys_mode;
  assign fire    = fetch_go && !blocked;

  logic [SEQ_W-1:0] seq_q;
  fgx_accum #(.W(SEQ_W), .STEP_W(CW)) seq_i (
    .clk(clk), .rst_n(rst_n), .en(fire), .step(w_count), .q(seq_q)
  );
  fgx_accum #(.W(SEQ_W), .STEP_W(1)) brc_i (
    .clk(clk), .rst_n(rst_n), .en(fire), .step(w_taken), .q(taken_cnt)
  );

  logic [FETCH_W*IW-1:0]    inst_n;
  logic [FETCH_W*SEQ_W-1:0] seq_n;
  always_comb begin
    inst_n = '0;
    seq_n  = '0;
    for (int s = 0; s < FETCH_W; s++) begin
      if (w_valid[s]) begin
        inst_n[s*IW +: IW]      = line_data[int'(w_idx[s*WIDX +: WIDX])*IW +: IW];
        seq_n[s*SEQ_W +: SEQ_W] = seq_q + SEQ_W'(s);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_valid   <= 1'b0;
      grp_count   <= '0;
      slot_valid  <= '0;
      slot_inst   <= '0;
      slot_pc     <= '0;
      slot_tgt    <= '0;
      slot_seq    <= '0;
      pc_q        <= '0;
      pc_next_q   <= '0;
      quiesce_req <= 1'b0;
    end else if (fire) begin
      grp_valid   <= (w_count != '0);
      grp_count   <= w_count;
      slot_valid  <= w_valid;
      slot_inst   <= inst_n;
      slot_pc     <= w_pc;
      slot_tgt    <= w_tgt;
      slot_seq    <= seq_n;
      pc_q        <= w_next_pc;
      pc_next_q   <= w_next_pc + ADDR_W'(fgx_pkg::INST_BYTES);
      quiesce_req <= w_quiesce;
    end else begin
      grp_valid   <= 1'b0;
      grp_count   <= '0;
      slot_valid  <= '0;
      slot_inst   <= '0;
      slot_pc     <= '0;
      slot_tgt    <= '0;
      slot_seq    <= '0;
      quiesce_req <= 1'b0;
    end
  end

  assert_blocked_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> (!grp_valid && $stable(pc_q) && $stable(taken_cnt)));
  assert_count_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(slot_valid) == int'(grp_count)) && (int'(grp_count) <= FETCH_W));
  assert_valid_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid == (grp_count != '0));
  assert_pc_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |-> (pc_next_q == pc_q + ADDR_W'(fgx_pkg::INST_BYTES)));
  assert_quiesce_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
    quiesce_req |-> grp_valid);
  assert_seq_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && slot_valid[FETCH_W > 1 ? 1 : 0] && FETCH_W > 1) |->
      (slot_seq[(FETCH_W > 1 ? 1 : 0)*SEQ_W +: SEQ_W] == slot_seq[SEQ_W-1:0] + SEQ_W'(FETCH_W > 1 ? 1 : 0)));
endmodule

// File: tb/fgx_group_extract_tb_top.sv
module fgx_group_extract_tb_top;
  localparam int FW = 4, LB = 64, AW = 32, SW = 16, NW = LB / 4, CW = $clog2(FW + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic fetch_go = 0, intr_pending = 0, phys_mode = 0;
  logic [AW-1:0] fetch_pc = '0;
  logic [LB*8-1:0] line_data;
  logic [NW-1:0] ctrl_mask, quiesce_mask, pred_taken;
  logic [NW*AW-1:0] pred_target;
  logic grp_valid, quiesce_req;
  logic [CW-1:0] grp_count;
  logic [FW-1:0] slot_valid;
  logic [FW*32-1:0] slot_inst;
  logic [FW*AW-1:0] slot_pc, slot_tgt;
  logic [FW*SW-1:0] slot_seq;
  logic [AW-1:0] pc_q, pc_next_q;
  logic [SW-1:0] taken_cnt;

  logic [31:0] m_line [NW];
  logic [AW-1:0] m_tgt [NW];
  logic m_ctl [NW], m_qz [NW], m_tk [NW];

  always_comb begin
    for (int w = 0; w < NW; w++) begin
      line_data[w*32 +: 32] = m_line[w];
      pred_target[w*AW +: AW] = m_tgt[w];
      ctrl_mask[w] = m_ctl[w];
      quiesce_mask[w] = m_qz[w];
      pred_taken[w] = m_tk[w];
    end
  end

  fgx_group_extract dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_go(fetch_go), .fetch_pc(fetch_pc),
    .line_data(line_data), .ctrl_mask(ctrl_mask), .quiesce_mask(quiesce_mask),
    .pred_taken(pred_taken), .pred_target(pred_target),
    .intr_pending(intr_pending), .phys_mode(phys_mode),
    .grp_valid(grp_valid), .grp_count(grp_count), .slot_valid(slot_valid),
    .slot_inst(slot_inst), .slot_pc(slot_pc), .slot_tgt(slot_tgt), .slot_seq(slot_seq),
    .pc_q(pc_q), .pc_next_q(pc_next_q), .quiesce_req(quiesce_req), .taken_cnt(taken_cnt)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model state
  longint m_seq = 0, m_br = 0, m_pc = 0, m_pcn = 0;
  int e_cnt; bit e_q;
  longint e_inst [FW], e_pc [FW], e_tgt [FW], e_seq [FW];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_line(input int salt);
    for (int w = 0; w < NW; w++) begin
      m_line[w] = 32'h1000_0000 + 32'(w * 17) + 32'(salt << 8);
      m_tgt[w] = '0; m_ctl[w] = 0; m_qz[w] = 0; m_tk[w] = 0;
    end
  endtask

  task automatic predict(input bit go, input longint fpc, input bit ip, input bit ph);
    int off; longint pc, nxt; bit stop;
    e_cnt = 0; e_q = 0; stop = 0;
    for (int s = 0; s < FW; s++) begin e_inst[s] = 0; e_pc[s] = 0; e_tgt[s] = 0; e_seq[s] = 0; end
    if (go && !(ip && !ph)) begin
      off = ((int'(fpc % 64)) / 4) * 4;
      pc = (fpc / 4) * 4;
      while (!stop && off < LB && e_cnt < FW) begin
        int w;
        w = off / 4;
        nxt = m_ctl[w] ? longint'(m_tgt[w]) : (pc + 4) % (longint'(1) << 32);
        e_inst[e_cnt] = longint'(m_line[w]);
        e_pc[e_cnt] = pc; e_tgt[e_cnt] = nxt;
        e_seq[e_cnt] = (m_seq + e_cnt) % 65536;
        if (m_ctl[w] && m_tk[w]) begin stop = 1; m_br++; end
        if (m_qz[w]) begin stop = 1; e_q = 1; end
        pc = nxt; off += 4; e_cnt++;
      end
      m_seq += e_cnt;
      m_pc = pc; m_pcn = (pc + 4) % (longint'(1) << 32);
    end
  endtask

  task automatic compare(input string req);
    chk(req, "grp_valid", longint'(grp_valid), longint'(e_cnt > 0));
    chk(req, "grp_count", longint'(grp_count), longint'(e_cnt));
    for (int s = 0; s < FW; s++) begin
      chk(req, $sformatf("slot%0d valid", s), longint'(slot_valid[s]), longint'(s < e_cnt));
      chk(req, $sformatf("slot%0d inst", s), longint'(slot_inst[s*32 +: 32]), e_inst[s]);
      chk(req, $sformatf("slot%0d pc", s), longint'(slot_pc[s*AW +: AW]), e_pc[s]);
      chk(req, $sformatf("slot%0d tgt", s), longint'(slot_tgt[s*AW +: AW]), e_tgt[s]);
      chk(req, $sformatf("slot%0d seq", s), longint'(slot_seq[s*SW +: SW]), e_seq[s]);
    end
    chk(req, "pc_q", longint'(pc_q), m_pc);
    chk(req, "pc_next_q", longint'(pc_next_q), m_pcn);
    chk(req, "quiesce_req", longint'(quiesce_req), longint'(e_q));
    chk(req, "taken_cnt", longint'(taken_cnt), m_br % 65536);
  endtask

  task automatic step(input string req, input bit go, input logic [AW-1:0] pc, input bit ip, input bit ph);
    fetch_go = go; fetch_pc = pc; intr_pending = ip; phys_mode = ph;
    predict(go, longint'(pc), ip, ph);
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_line(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    predict(0, 0, 0, 0);
    compare("R1");

    // Straight-line group limited by width
    step("R4_R5", 1, 32'h0000_1000, 0, 0);

    // Start two words before line end, unaligned low bits
    clear_line(1);
    step("R2_R3", 1, 32'h0000_203A, 0, 0);

    // Taken branch at word 1 ends the group
    clear_line(2);
    m_ctl[1] = 1; m_tk[1] = 1; m_tgt[1] = 32'h4444_0010;
    step("R6_taken", 1, 32'h0000_3000, 0, 0);

    // Not-taken control word with a target outside the line
    clear_line(3);
    m_ctl[2] = 1; m_tk[2] = 0; m_tgt[2] = 32'h0000_5100;
    step("R6_nottaken", 1, 32'h0000_5008, 0, 0);

    // Quiesce word mid-group
    clear_line(4);
    m_qz[3] = 1;
    step("R7", 1, 32'h0000_6004, 0, 0);
    clear_line(5);
    step("R7_clear", 0, 32'h0000_6004, 0, 0);

    // Interrupt waiting: suppressed, then physical mode proceeds
    clear_line(6);
    m_ctl[0] = 1; m_tk[0] = 1; m_tgt[0] = 32'h0000_9000;
    step("R9_block", 1, 32'h0000_7000, 1, 0);
    step("R9_phys", 1, 32'h0000_7000, 1, 1);

    // Idle cycle and sequence continuity
    step("R10_idle", 0, 32'h0000_0000, 0, 0);
    clear_line(7);
    step("R8", 1, 32'h0000_8030, 0, 0);
    step("R8_next", 1, 32'h0000_8000, 0, 0);

    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule